// File: doc/BRIEF.md
# Interrupt and Exception Entry/Return Sequencer

This block is the control engine a small 16-bit processor uses to enter a service routine and to come back from it. It handles three requests: a timer-style interrupt, a memory protection exception, and a decoded return-from-interrupt instruction (opcode 1000). A request is accepted only while the sequencer is idle, which is at an instruction boundary.

On entry, the sequencer first bumps its own stack pointer. It then writes the saved program counter into the stack word the pointer now addresses. Last, it hands the processor a new program counter taken from one of two vector registers. For an exception the saved value is the current program counter minus one, so the handler sees the address of the faulting instruction.

On return, the sequencer reads the word at the stack pointer and lowers the pointer by one. It then hands the read word back as the program counter. Condition codes and general registers are not saved; the service routine must preserve them itself. The program counter register lives outside the block, and the block reads and writes it through ports. The stack memory is external, with a write port and an asynchronous read port.

Top module: `trapSequencer`

## Requirements
- R1: After reset the stack pointer reads 0x1FFF. `done`, `pcWe`, `memWe` and `memRe` are all low.
- R2: An accepted interrupt (idle, `intReq` high at a rising edge) leads to the following. In the second cycle after acceptance, the stack pointer already holds its old value plus one, and a stack write is issued to that new address carrying the `pcIn` value seen at acceptance.
- R3: In the third cycle after an accepted interrupt, `pcWe` is high with `pcWrData` = 0x0200 (the interrupt vector).
- R4: An accepted exception pushes `pcIn` minus one (taken at acceptance) to the pre-incremented stack address, with the same timing as R2.
- R5: In the third cycle after an accepted exception, `pcWe` is high with `pcWrData` = 0x0300 (the exception vector).
- R6: An accepted return issues a stack read at the current stack pointer in the next cycle. One cycle later, `pcWe` is high with `pcWrData` equal to the word read, and the stack pointer is one lower.
- R7: `done` is high for exactly the one cycle in which `pcWe` is high, and is low at all other times.
- R8: Simultaneous requests are ranked exception over interrupt over return; only the highest is served.
- R9: Requests arriving while a sequence is in progress are ignored. No extra stack write, program counter write or stack pointer change follows the sequence.
- R10: An exception taken with `pcIn` = 0x0000 pushes 0xFFFF; all program counter and stack arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| intReq | input | 1 | Interrupt pending at the instruction boundary |
| excReq | input | 1 | Protection exception detected |
| retReq | input | 1 | Return-from-interrupt opcode decoded |
| pcIn | input | DATA_W | Current program counter value |
| pcWrData | output | DATA_W | New program counter value |
| pcWe | output | 1 | Load `pcWrData` into the program counter |
| spOut | output | DATA_W | Current stack pointer |
| memAddr | output | DATA_W | Stack memory address |
| memWrData | output | DATA_W | Stack memory write data |
| memWe | output | 1 | Stack memory write strobe |
| memRe | output | 1 | Stack memory read strobe |
| memRdData | input | DATA_W | Stack memory read data (same cycle) |
| done | output | 1 | Sequence complete, new program counter in place |

## Verification
The bench uses the default parameters: a 16-bit word, a stack pointer starting at 0x1FFF, and vectors 0x0200 and 0x0300. With those values the first pushes land at 0x2000 and 0x2001, so a 256-word model memory indexed by the low address bits holds every stacked word. This allows nested entries to be unwound in last-in, first-out order. A 16-bit width also makes the exception rewind from program counter zero reach the 0xFFFF wrap with a single entry.

// File: rtl/trapSeqPkg.sv
package trapSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BUMP,
    ST_PUSH,
    ST_VECTOR,
    ST_POP,
    ST_RESUME
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic capPc;      // latch the program counter to be saved
    logic capExc;     // latched entry is an exception (rewind and vector)
    logic spInc;      // pre-increment for a push
    logic spDec;      // post-read decrement for a pop
    logic memWr;      // write saved value to stack
    logic memRd;      // read stacked value into save register
    logic loadVec;    // drive vector onto program counter
    logic loadSaved;  // drive popped value onto program counter
  } seqStrobeT;

endpackage

// File: rtl/trapSeqCtrl.sv
module trapSeqCtrl
  import trapSeqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      intReq,
  input  logic      excReq,
  input  logic      retReq,
  output seqStrobeT strobe,
  output logic      done
);

  seqStateT state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        // priority: exception, then interrupt, then return
        if (excReq) begin
          strobe.capPc  = 1'b1;
          strobe.capExc = 1'b1;
          nextState     = ST_BUMP;
        end else if (intReq) begin
          strobe.capPc  = 1'b1;
          nextState     = ST_BUMP;
        end else if (retReq) begin
          nextState     = ST_POP;
        end
      end
      ST_BUMP: begin
        strobe.spInc = 1'b1;
        nextState    = ST_PUSH;
      end
      ST_PUSH: begin
        strobe.memWr = 1'b1;
        nextState    = ST_VECTOR;
      end
      ST_VECTOR: begin
        strobe.loadVec = 1'b1;
        done           = 1'b1;
        nextState      = ST_IDLE;
      end
      ST_POP: begin
        strobe.memRd = 1'b1;
        strobe.spDec = 1'b1;
        nextState    = ST_RESUME;
      end
      ST_RESUME: begin
        strobe.loadSaved = 1'b1;
        done             = 1'b1;
        nextState        = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/trapSeqPath.sv
module trapSeqPath
  import trapSeqPkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] SP_INIT  = 16'h1FFF,
  parameter logic [DATA_W-1:0] INT_VEC  = 16'h0200,
  parameter logic [DATA_W-1:0] EXC_VEC  = 16'h0300
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strobe,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] pcWrData,
  output logic              pcWe,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWe,
  output logic              memRe
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] stackPtr;
  logic [DATA_W-1:0] savedPc;
  logic [DATA_W-1:0] intVecReg;
  logic [DATA_W-1:0] excVecReg;
  logic              excKind;

  // vector registers, each initialised on reset to its own value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intVecReg <= INT_VEC;
      excVecReg <= EXC_VEC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             stackPtr <= SP_INIT;
    else if (strobe.spInc) stackPtr <= stackPtr + ONE;
    else if (strobe.spDec) stackPtr <= stackPtr - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedPc <= '0;
      excKind <= 1'b0;
    end else if (strobe.capPc) begin
      savedPc <= strobe.capExc ? pcIn - ONE : pcIn;
      excKind <= strobe.capExc;
    end else if (strobe.memRd) begin
      savedPc <= memRdData;
    end
  end

  assign spOut     = stackPtr;
  assign memAddr   = stackPtr;
  assign memWrData = savedPc;
  assign memWe     = strobe.memWr;
  assign memRe     = strobe.memRd;
  assign pcWe      = strobe.loadVec | strobe.loadSaved;
  assign pcWrData  = strobe.loadSaved ? savedPc
                   : (excKind ? excVecReg : intVecReg);

endmodule

// File: rtl/trapSequencer.sv
module trapSequencer
  import trapSeqPkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] SP_INIT = 16'h1FFF,
  parameter logic [DATA_W-1:0] INT_VEC = 16'h0200,
  parameter logic [DATA_W-1:0] EXC_VEC = 16'h0300
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intReq,
  input  logic              excReq,
  input  logic              retReq,
  input  logic [DATA_W-1:0] pcIn,
  output logic [DATA_W-1:0] pcWrData,
  output logic              pcWe,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWe,
  output logic              memRe,
  input  logic [DATA_W-1:0] memRdData,
  output logic              done
);

  seqStrobeT strobe;

  trapSeqCtrl ctrlI (
    .clk    (clk),
    .rstN   (rstN),
    .intReq (intReq),
    .excReq (excReq),
    .retReq (retReq),
    .strobe (strobe),
    .done   (done)
  );

  trapSeqPath #(
    .DATA_W  (DATA_W),
    .SP_INIT (SP_INIT),
    .INT_VEC (INT_VEC),
    .EXC_VEC (EXC_VEC)
  ) pathI (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pcIn      (pcIn),
    .memRdData (memRdData),
    .pcWrData  (pcWrData),
    .pcWe      (pcWe),
    .spOut     (spOut),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .memWe     (memWe),
    .memRe     (memRe)
  );

endmodule

// File: rtl/trapSeqChecks.sv
module trapSeqChecks #(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] INT_VEC = 16'h0200,
  parameter logic [DATA_W-1:0] EXC_VEC = 16'h0300
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] pcWrData,
  input logic              pcWe,
  input logic [DATA_W-1:0] spOut,
  input logic              memWe,
  input logic              memRe,
  input logic              done
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  // R2, R6: stack pointer moves by at most one per cycle
  assert_sp_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (spOut == $past(spOut) || spOut == $past(spOut) + ONE || spOut == $past(spOut) - ONE));

  // R7: done lasts one cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: done accompanies the program counter load
  assert_done_with_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> pcWe);

  // R2, R6: a program counter load follows a stack access
  assert_load_after_stack_R6: assert property (@(posedge clk) disable iff (!rstN)
    pcWe |-> ($past(memWe) || $past(memRe)));

  // R3, R5: an entry loads one of the two vectors
  assert_entry_vector_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pcWe && $past(memWe)) |-> (pcWrData == INT_VEC || pcWrData == EXC_VEC));

  // R6: never read and write the stack together
  assert_rw_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

endmodule

bind trapSequencer trapSeqChecks #(
  .DATA_W  (DATA_W),
  .INT_VEC (INT_VEC),
  .EXC_VEC (EXC_VEC)
) checksI (
  .clk      (clk),
  .rstN     (rstN),
  .pcWrData (pcWrData),
  .pcWe     (pcWe),
  .spOut    (spOut),
  .memWe    (memWe),
  .memRe    (memRe),
  .done     (done)
);

// File: tb/trapSequencer_test.sv
module trapSequencer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        intReq = 1'b0, excReq = 1'b0, retReq = 1'b0;
  logic [15:0] pcModel = 16'h0000;
  logic [15:0] pcWrData, spOut, memAddr, memWrData, memRdData;
  logic        pcWe, memWe, memRe, done;
  logic        pcLoad = 1'b0;
  logic [15:0] pcLoadVal = 16'h0000;
  logic [15:0] mem [0:255];

  int total = 0;
  int failed = 0;
  int cycles = 0;
  bit summaryDone = 0;
  logic [15:0] expSp = 16'h1FFF;

  always #2 clk = ~clk;

  trapSequencer uut (
    .clk(clk), .rstN(rstN), .intReq(intReq), .excReq(excReq), .retReq(retReq),
    .pcIn(pcModel), .pcWrData(pcWrData), .pcWe(pcWe), .spOut(spOut),
    .memAddr(memAddr), .memWrData(memWrData), .memWe(memWe), .memRe(memRe),
    .memRdData(memRdData), .done(done)
  );

  assign memRdData = mem[memAddr[7:0]];

  always @(posedge clk) begin
    if (memWe) mem[memAddr[7:0]] <= memWrData;
    if (pcWe) pcModel <= pcWrData;
    else if (pcLoad) pcModel <= pcLoadVal;
  end

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  %0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; failed++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      summary();
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic setPc(logic [15:0] v);
    @(negedge clk); pcLoad = 1'b1; pcLoadVal = v;
    @(negedge clk); pcLoad = 1'b0;
  endtask

  // entry: drive requests one cycle; poke = raise other requests while busy
  task automatic doEntry(bit i, bit e, bit r, bit isExc, bit poke, string tagP, string tagV);
    logic [15:0] oldPc, pushed, vec;
    oldPc  = pcModel;
    pushed = isExc ? oldPc - 16'h1 : oldPc;
    vec    = isExc ? 16'h0300 : 16'h0200;
    @(negedge clk); intReq = i; excReq = e; retReq = r;
    @(negedge clk); intReq = poke; excReq = poke; retReq = poke;
    chk({tagP, " no write yet"}, {15'd0, memWe}, 16'd0);
    @(negedge clk);
    chk({tagP, " sp pre-incremented"}, spOut, expSp + 16'h1);
    chk({tagP, " push strobe"}, {15'd0, memWe}, 16'd1);
    chk({tagP, " push addr"}, memAddr, expSp + 16'h1);
    chk({tagP, " push data"}, memWrData, pushed);
    intReq = 1'b0; excReq = 1'b0; retReq = 1'b0;
    @(negedge clk);
    chk({tagV, " pc load"}, {15'd0, pcWe}, 16'd1);
    chk({tagV, " vector"}, pcWrData, vec);
    chk("R7 done with load", {15'd0, done}, 16'd1);
    expSp = expSp + 16'h1;
    @(negedge clk);
    chk("R7 done single", {15'd0, done}, 16'd0);
    chk({tagV, " pc now vector"}, pcModel, vec);
    if (poke) begin
      @(negedge clk);
      chk("R9 no extra write", {15'd0, memWe | memRe | pcWe}, 16'd0);
      @(negedge clk);
      chk("R9 sp unchanged", spOut, expSp);
      chk("R9 pc unchanged", pcModel, vec);
    end
  endtask

  task automatic doReturn(logic [15:0] expPc);
    @(negedge clk); retReq = 1'b1;
    @(negedge clk); retReq = 1'b0;
    chk("R6 read strobe", {15'd0, memRe}, 16'd1);
    chk("R6 read addr", memAddr, expSp);
    @(negedge clk);
    chk("R6 pc load", {15'd0, pcWe}, 16'd1);
    chk("R6 popped value", pcWrData, expPc);
    chk("R6 sp decremented", spOut, expSp - 16'h1);
    chk("R7 done on return", {15'd0, done}, 16'd1);
    expSp = expSp - 16'h1;
    @(negedge clk);
    chk("R7 done cleared", {15'd0, done}, 16'd0);
    chk("R6 pc restored", pcModel, expPc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sp reset", spOut, 16'h1FFF);
    chk("R1 strobes idle", {12'd0, done, pcWe, memWe, memRe}, 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {12'd0, done, pcWe, memWe, memRe}, 16'd0);

    setPc(16'h0450);
    doEntry(1, 0, 0, 0, 0, "R2", "R3");       // interrupt
    doReturn(16'h0450);                      // back to 0x0450, sp 0x1FFF
    setPc(16'h0451);
    doEntry(0, 1, 0, 1, 1, "R4", "R5");       // exception, busy pokes (R9)
    setPc(16'h0600);
    doEntry(1, 0, 0, 0, 0, "R2 nested", "R3 nested");
    doReturn(16'h0600);                      // last in, first out
    doReturn(16'h0450);                      // exception save
    chk("R6 sp back to reset", spOut, 16'h1FFF);
    setPc(16'h0000);
    doEntry(1, 1, 1, 1, 0, "R10 R8 wrap", "R8 exception wins");
    setPc(16'h0777);
    doEntry(1, 0, 1, 0, 0, "R8 int over ret", "R8 int vector");
    summary();
  end

endmodule